// File: doc/BRIEF.md
# Integer clock divider with balanced duty cycle

This block divides an incoming clock by a fixed integer ratio `N` and produces an output whose high and low times are equal. This holds for odd ratios as well as even ones. A synchronous counter on the rising edge repeats a cycle of `N` states. A comparator turns the counter value into a single registered pulse train. That pulse train is high for `floor(N/2)` consecutive input cycles in every period and low for the rest.

The pulse has fewer high cycles than low ones. A widening stage closes that gap by ORing the pulse with delayed copies of itself. The number of copies comes from half the difference between low and high cycles: one rising-edge flop for each whole cycle of that half-difference, and one falling-edge flop for a leftover half cycle. With the chosen pulse, even ratios need no copy. Odd ratios need exactly one half-cycle copy, which stretches the high time by half an input period.

The block has no data path, so there is no valid/ready handshake; all pins are plain control pins. The ratio is a parameter, and a value below 2 stops elaboration with an error.

Top module: `clkdiv_half_duty`

## Requirements
- R1: The internal counter steps by one on every rising input edge outside reset and returns to 0 after reaching N-1, so it cycles through 0 to N-1.
- R2: Outside reset, consecutive rising edges of `clk_out` are exactly N input clock periods apart.
- R3: Outside reset, `clk_out` is high for exactly N/2 input periods and low for exactly N/2 input periods (for example 1.5 and 1.5 for N=3, 3.5 and 3.5 for N=7).
- R4: `rst` is active high and sampled synchronously. From the second input clock edge (rising or falling) at which `rst` is seen high, `clk_out` is low and stays low while `rst` stays high.
- R5: After `rst` is released, the first rising edge of `clk_out` occurs at rising input edge number ceil(N/2)+1, counting the first rising edge that samples `rst` low as number 1.
- R6: With N=2 the output is a plain toggle: high for one input period, low for one input period.
- R7: Every rising edge of `clk_out` coincides with a rising input edge. A falling edge of `clk_out` coincides with a falling input edge when N is odd, and with a rising input edge when N is even.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| clk_out | output | 1 | Divided clock, period N input cycles, 50% duty |

## Verification
The assertions assume that `rst` changes only away from both edges of `clk`, because the half-cycle stage samples it on the falling edge and the counter samples it on the rising edge. They also assume that `clk` is free-running with a steady period, since equal high and low times depend on the input duty being 50%. The stimulus drives `rst` one nanosecond after a rising edge and never stops the clock. Several ratios are instantiated side by side, both odd and even, and a reset is applied in the middle of a run to exercise the truncated pulse and the restart timing.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // Number of high cycles of the registered pulse taken from the counter.
  function automatic int pulse_high(input int n);
    return n / 2;
  endfunction

  // Imbalance between low and high cycles of that pulse.
  function automatic int pulse_gap(input int n);
    return (n - pulse_high(n)) - pulse_high(n);
  endfunction

  // Whole-cycle delay flops needed: integer part of half the gap.
  function automatic int full_delay_count(input int n);
    return pulse_gap(n) / 2;
  endfunction

  // Half-cycle delay flop needed when half the gap leaves a half.
  function automatic int half_delay_count(input int n);
    return pulse_gap(n) % 2;
  endfunction

endpackage

// File: rtl/clkdiv_modn_counter.sv
`timescale 1ns/1ps
module clkdiv_modn_counter #(
  parameter int N  = 7,
  parameter int CW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cnt) != LAST) |-> (cnt == $past(cnt) + 1'b1)); // R1
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cnt) == LAST) |-> (cnt == '0)); // R1
endmodule

// File: rtl/clkdiv_tap.sv
`timescale 1ns/1ps
module clkdiv_tap #(
  parameter int N  = 7,
  parameter int CW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  output logic          tap
);
  import clkdiv_pkg::*;

  // Threshold leaves pulse_high(N) counter states at or above it.
  localparam int THRESH = N - pulse_high(N);
  localparam logic [CW-1:0] THR   = CW'(THRESH);
  localparam logic [CW-1:0] ROSEV = CW'((THRESH + 1) % N);

  always_ff @(posedge clk) begin
    if (rst) tap <= 1'b0;
    else     tap <= (cnt >= THR);
  end

  // The pulse starts only when the counter has just left the threshold value.
  AST_TAP_ROSE: assert property (@(posedge clk) disable iff (rst)
    $rose(tap) |-> (cnt == ROSEV)); // R5
endmodule

// File: rtl/clkdiv_widen.sv
`timescale 1ns/1ps
module clkdiv_widen #(
  parameter int FULL_STAGES = 0,
  parameter int HALF_STAGE  = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tap_in,
  output logic clk_out
);
  logic [FULL_STAGES:0] stage;
  logic                 half_q;

  assign stage[0] = tap_in;

  // One rising-edge flop per whole cycle of imbalance.
  for (genvar i = 0; i < FULL_STAGES; i++) begin : g_full
    always_ff @(posedge clk) begin
      if (rst) stage[i+1] <= 1'b0;
      else     stage[i+1] <= stage[i];
    end
  end

  // One falling-edge flop for a leftover half cycle.
  if (HALF_STAGE != 0) begin : g_half
    always_ff @(negedge clk) begin
      if (rst) half_q <= 1'b0;
      else     half_q <= stage[FULL_STAGES];
    end

    // The half-cycle copy seen at a rising edge equals the last chain stage.
    AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (rst)
      half_q == stage[FULL_STAGES]); // R3
  end else begin : g_nohalf
    assign half_q = 1'b0;
  end

  assign clk_out = (|stage) | half_q;
endmodule

// File: rtl/clkdiv_half_duty.sv
`timescale 1ns/1ps
module clkdiv_half_duty #(
  parameter int N = 7
) (
  input  logic clk,
  input  logic rst,
  output logic clk_out
);
  import clkdiv_pkg::*;

  localparam int CW    = (N > 1) ? $clog2(N) : 1;
  localparam int NFULL = full_delay_count(N);
  localparam int NHALF = half_delay_count(N);

  if (N < 2) begin : g_bad_ratio
    $error("clkdiv_half_duty: division ratio must be at least 2");
  end

  logic [CW-1:0] cnt;
  logic          tap;

  clkdiv_modn_counter #(.N(N), .CW(CW)) u_cnt (
    .clk (clk),
    .rst (rst),
    .cnt (cnt)
  );

  clkdiv_tap #(.N(N), .CW(CW)) u_tap (
    .clk (clk),
    .rst (rst),
    .cnt (cnt),
    .tap (tap)
  );

  clkdiv_widen #(.FULL_STAGES(NFULL), .HALF_STAGE(NHALF)) u_widen (
    .clk     (clk),
    .rst     (rst),
    .tap_in  (tap),
    .clk_out (clk_out)
  );

  AST_RST_LOW: assert property (@(posedge clk)
    (rst && $past(rst)) |-> !clk_out); // R4
endmodule

// File: tb/tb_clkdiv_half_duty.sv
`timescale 1ns/1ps
module tb_clkdiv_half_duty;
  localparam real TCLK = 10.0;
  localparam int  NCFG = 5;
  localparam int  NLIST [NCFG] = '{2, 3, 5, 7, 8};

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #(TCLK/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int nv,
                     input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s N=%0d actual=%0.3f expected=%0.3f at %0t",
               req, nv, act, exp, $realtime);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < 0.001) && (b - a < 0.001);
  endfunction

  for (genvar gi = 0; gi < NCFG; gi++) begin : g_cfg
    localparam int NV   = NLIST[gi];
    localparam int HIGH = NV / 2;
    localparam int THR  = NV - HIGH;
    localparam bit ODD  = (NV % 2) == 1;

    logic clk_out;

    clkdiv_half_duty #(.N(NV)) dut (
      .clk     (clk),
      .rst     (rst),
      .clk_out (clk_out)
    );

    // Behavioural reference: a phase number and the two level terms.
    int  phase = 0;
    bit  lvl_a = 1'b0;
    bit  lvl_b = 1'b0;
    bit  armed = 1'b0;

    always @(posedge clk) begin
      bit rs;
      bit e;
      rs = rst;
      if (rs) begin
        phase = 0;
        lvl_a = 1'b0;
      end else begin
        lvl_a = (phase >= THR);
        phase = (phase + 1) % NV;
      end
      #(TCLK/4);
      if (armed) begin
        e = lvl_a | (ODD & lvl_b);
        chk(clk_out === e, rs ? "R4" : "R3", NV, real'(clk_out), real'(e));
      end
    end

    always @(negedge clk) begin
      bit rs;
      bit e;
      rs = rst;
      lvl_b = rs ? 1'b0 : lvl_a;
      if (rs) armed = 1'b1;
      #(TCLK/4);
      if (armed) begin
        e = lvl_a | (ODD & lvl_b);
        chk(clk_out === e, rs ? "R4" : "R3", NV, real'(clk_out), real'(e));
      end
    end

    // Edge timing monitor.
    realtime t_rise   = 0.0;
    realtime t_first  = 0.0;
    bit      rise_ok  = 1'b0;
    bit      pending  = 1'b0;

    always @(posedge rst) rise_ok = 1'b0;

    always @(negedge rst) begin
      pending = 1'b1;
      t_first = $realtime + (TCLK - 1.0) + THR * TCLK;
    end

    always @(posedge clk_out) begin
      if (!rst) begin
        chk(clk === 1'b1, "R7", NV, real'(clk), 1.0);
        if (pending) begin
          chk(near($realtime, t_first), "R5", NV, $realtime, t_first);
          pending = 1'b0;
        end
        if (rise_ok)
          chk(near($realtime - t_rise, NV * TCLK), (NV == 2) ? "R6" : "R1 R2",
              NV, $realtime - t_rise, NV * TCLK);
        t_rise  = $realtime;
        rise_ok = 1'b1;
      end
    end

    always @(negedge clk_out) begin
      if (!rst && rise_ok && clk_out === 1'b0) begin
        chk(clk === (ODD ? 1'b0 : 1'b1), "R7", NV, real'(clk), ODD ? 0.0 : 1.0);
        chk(near($realtime - t_rise, NV * TCLK / 2.0), (NV == 2) ? "R6" : "R3",
            NV, $realtime - t_rise, NV * TCLK / 2.0);
      end
    end
  end

  initial begin
    rst = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (61) @(posedge clk);
    #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    repeat (83) @(posedge clk);
    #1 rst = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (40) @(posedge clk);
    #3;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule